// File: doc/BRIEF.md
# Double-Buffered Serial Receive Path

This block turns an oversampled asynchronous serial line into characters that a host can read. A shift stage collects the bits of the incoming frame one at a time. When the last bit has been sampled, the finished character is copied in one step into a holding register. The host reads only the holding register, so the next frame can arrive while the previous character is still unread. Bit timing comes from a sampling enable that pulses sixteen times per bit period. A 4-bit counter divides it down to one sampling point per bit, placed at the middle of the bit.

Four frame formats are supported: 7 data bits, 8 data bits, 8 data bits plus a parity bit, and 9 data bits. The parity bit, or the ninth data bit, goes into a separate flag output. The block flags an overrun when the host falls behind. In 9-bit format it can filter frames on their ninth bit, so that a listener on a multi-drop line wakes only on address frames. The receive interrupt can be driven as a level or as a single-cycle pulse.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After reset, rx_data is 0 and rx_flag, overrun and irq are all 0.
- R2: A frame starts when rxd has been low on 8 consecutive sampling ticks. Each data bit is then sampled 16 ticks after the previous sampling point, LSB first. In format 1 (8 data bits) the 8 bits appear on rx_data and rx_flag is written 0.
- R3: In format 0 (7 data bits), rx_data[6:0] carries the bits and rx_data[7] reads 0.
- R4: In format 2, the ninth bit sampled (the parity bit) is written to rx_flag. In format 3 (9 data bits), the ninth data bit (the MSB) is written to rx_flag. In both formats rx_data carries the first 8 bits.
- R5: If a frame completes while the holding register is full and rd_strobe is low in that cycle, then overrun goes to 1. rx_data and rx_flag keep their values, the new frame is dropped, and no interrupt event occurs.
- R6: A rd_strobe cycle with no transfer empties the holding register and clears overrun. If a transfer and rd_strobe fall in the same cycle, the transfer wins: the new character is loaded and overrun stays 0.
- R7: With wake_en=1 in format 3, a frame whose ninth bit is 0 is dropped. It leaves rx_data and rx_flag unchanged, raises no interrupt and sets no overrun. A frame whose ninth bit is 1 is accepted normally.
- R8: With irq_edge=0 (level mode), irq is 1 from the cycle after a transfer until the holding register is read.
- R9: With irq_edge=1 (edge mode), each transfer produces exactly one single-cycle irq pulse.
- R10: A low pulse on rxd that lasts fewer than 8 sampling ticks is ignored.
- R11: The bit logic advances only on cycles where tick16 is 1. A bit period is therefore 16 ticks, whatever the spacing of the ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sampling enable, sixteen pulses per bit period |
| rxd | input | 1 | Serial line, idle high |
| fmt | input | 2 | Frame format: 0 = 7 bits, 1 = 8 bits, 2 = 8 bits + parity, 3 = 9 bits |
| wake_en | input | 1 | Ninth-bit address filter enable (format 3 only) |
| irq_edge | input | 1 | 1 = pulse interrupt, 0 = level interrupt |
| rd_strobe | input | 1 | Host read of the holding register, one cycle |
| rx_data | output | 8 | Holding register |
| rx_flag | output | 1 | Parity or ninth data bit of the held character |
| overrun | output | 1 | Character lost because the holding register was not read |
| irq | output | 1 | Receive interrupt |

## Verification
Suppose the sampling counter or the bit index goes wrong. Every character of the same frame then shows at rx_data with shifted or swapped bits, and the error is visible right after the transfer at the mid-point of the last bit. A wrong buffer-full state shows in two ways. In level mode irq is stuck or missing. On the next frame, overrun is set wrongly or missed, and the holding register is overwritten when it should be kept. Both appear within one frame time. A fault in the ninth-bit filter or in the read/transfer priority changes the held data of that same frame, so single directed frames expose it.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int WORD_W = 9;

    typedef enum logic [1:0] {
        FMT_7B     = 2'd0,
        FMT_8B     = 2'd1,
        FMT_8B_PAR = 2'd2,
        FMT_9B     = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DATA = 2'd1,
        S_STOP = 2'd2
    } rx_st_e;

    function automatic logic [3:0] frame_bits(fmt_e f);
        case (f)
            FMT_7B:  return 4'd7;
            FMT_8B:  return 4'd8;
            default: return 4'd9;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  fmt_e              fmt,
    output logic              done,
    output logic [WORD_W-1:0] word
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID_CNT  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OVS - 1);

    typedef struct packed {
        rx_st_e            st;
        logic [CW-1:0]     cnt;
        logic [3:0]        bidx;
        logic [WORD_W-1:0] sh;
        logic              done;
    } smp_t;

    smp_t s_q, s_d;
    logic [3:0] nbits;

    assign nbits = frame_bits(fmt);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (tick) begin
            case (s_q.st)
                S_IDLE: begin
                    if (rxd) begin
                        s_d.cnt = '0;
                    end else if (s_q.cnt == MID_CNT) begin
                        s_d.st   = S_DATA;
                        s_d.cnt  = '0;
                        s_d.bidx = '0;
                        s_d.sh   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (s_q.cnt == LAST_CNT) begin
                        s_d.cnt          = '0;
                        s_d.sh[s_q.bidx] = rxd;
                        if (s_q.bidx == nbits - 4'd1) begin
                            s_d.done = 1'b1;
                            s_d.st   = S_STOP;
                        end else begin
                            s_d.bidx = s_q.bidx + 4'd1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (s_q.cnt == LAST_CNT) begin
                        s_d.cnt = '0;
                        s_d.st  = S_IDLE;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: S_IDLE, cnt: '0, bidx: '0, sh: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done = s_q.done;
    assign word = s_q.sh;

    // R2: a completed frame is reported for exactly one cycle
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: no progress without a sampling tick
    p_tick_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q.cnt) && $stable(s_q.st) && !done);

    // R10: the bit phase is entered only after the line was seen low
    p_start_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_IDLE) ##1 (s_q.st == S_DATA) |-> !$past(rxd));

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [WORD_W-1:0] word,
    input  fmt_e              fmt,
    input  logic              wake_en,
    input  logic              irq_edge,
    input  logic              rd,
    output logic [7:0]        data,
    output logic              flag,
    output logic              ovr,
    output logic              irq
);
    typedef struct packed {
        logic [7:0] data;
        logic       flag;
        logic       full;
        logic       ovr;
        logic       pulse;
    } hold_t;

    hold_t h_q, h_d;
    logic  filtered;
    logic  accept;
    logic  ninth;

    assign filtered = wake_en && (fmt == FMT_9B) && !word[8];
    assign accept   = done && !filtered;
    assign ninth    = (fmt == FMT_8B_PAR || fmt == FMT_9B) ? word[8] : 1'b0;

    always_comb begin
        h_d       = h_q;
        h_d.pulse = 1'b0;
        if (accept && (!h_q.full || rd)) begin
            h_d.data  = word[7:0];
            h_d.flag  = ninth;
            h_d.full  = 1'b1;
            h_d.ovr   = 1'b0;
            h_d.pulse = 1'b1;
        end else if (accept) begin
            h_d.ovr = 1'b1;
        end else if (rd) begin
            h_d.full = 1'b0;
            h_d.ovr  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign data = h_q.data;
    assign flag = h_q.flag;
    assign ovr  = h_q.ovr;
    assign irq  = irq_edge ? h_q.pulse : h_q.full;

    // R5: an unread buffer survives a new frame, overrun is raised
    p_ovr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept && h_q.full && !rd |=> $stable(data) && $stable(flag) && ovr && !h_q.pulse);

    // R6: a plain read empties the buffer and clears overrun
    p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !done |=> !h_q.full && !ovr);

    // R7: a filtered frame touches nothing
    p_wake_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && filtered |=> $stable(data) && $stable(flag) && !h_q.pulse);

    // R9: an edge-mode event lasts one cycle
    p_edge_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        h_q.pulse |=> !h_q.pulse);

    // R8: level request sits high while data is waiting
    p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_edge && h_q.full |-> irq);

endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] fmt,
    input  logic       wake_en,
    input  logic       irq_edge,
    input  logic       rd_strobe,
    output logic [7:0] rx_data,
    output logic       rx_flag,
    output logic       overrun,
    output logic       irq
);
    fmt_e              fmt_s;
    logic              frame_done;
    logic [WORD_W-1:0] frame_word;

    assign fmt_s = fmt_e'(fmt);

    uart_rx_sampler #(.OVS(OVS)) u_smp (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick16),
        .rxd   (rxd),
        .fmt   (fmt_s),
        .done  (frame_done),
        .word  (frame_word)
    );

    uart_rx_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (frame_done),
        .word     (frame_word),
        .fmt      (fmt_s),
        .wake_en  (wake_en),
        .irq_edge (irq_edge),
        .rd       (rd_strobe),
        .data     (rx_data),
        .flag     (rx_flag),
        .ovr      (overrun),
        .irq      (irq)
    );

endmodule

// File: tb/tb_uart_rx_dbuf.sv
module tb_uart_rx_dbuf;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    typedef struct packed {
        logic [1:0] fmt;
        logic       wake;
        logic       edg;
        logic       rd;
        logic [8:0] bits;
        logic [7:0] d;
        logic       b9;
        logic       ovr;
        logic       irqv;
        logic [1:0] rise;
    } vec_t;

    // fmt wake edg rd bits data flag ovr irq rises
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 1'b0, 1'b0, 1'b1, 9'h0A5, 8'hA5, 1'b0, 1'b0, 1'b1, 2'd1},  // R2 R8
        '{2'd0, 1'b0, 1'b0, 1'b1, 9'h0D3, 8'h53, 1'b0, 1'b0, 1'b1, 2'd1},  // R3
        '{2'd2, 1'b0, 1'b0, 1'b1, 9'h13C, 8'h3C, 1'b1, 1'b0, 1'b1, 2'd1},  // R4
        '{2'd3, 1'b0, 1'b1, 1'b1, 9'h0C3, 8'hC3, 1'b0, 1'b0, 1'b0, 2'd1},  // R9
        '{2'd3, 1'b1, 1'b1, 1'b1, 9'h0E7, 8'hC3, 1'b0, 1'b0, 1'b0, 2'd0},  // R7 drop
        '{2'd3, 1'b1, 1'b1, 1'b1, 9'h15A, 8'h5A, 1'b1, 1'b0, 1'b0, 2'd1},  // R7 accept
        '{2'd3, 1'b1, 1'b0, 1'b0, 9'h066, 8'h5A, 1'b1, 1'b0, 1'b1, 2'd0},  // R7 no overrun
        '{2'd1, 1'b0, 1'b0, 1'b0, 9'h0F0, 8'h5A, 1'b1, 1'b1, 1'b1, 2'd0},  // R5
        '{2'd1, 1'b0, 1'b0, 1'b1, 9'h011, 8'h11, 1'b0, 1'b0, 1'b1, 2'd1},  // R6
        '{2'd1, 1'b0, 1'b1, 1'b0, 9'h022, 8'h11, 1'b0, 1'b1, 1'b0, 2'd0}   // R5 edge
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] fmt = 2'd1;
    logic       wake_en = 1'b0;
    logic       irq_edge = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_flag;
    logic       overrun;
    logic       irq;

    int  checks = 0;
    int  failures = 0;
    int  tick_div = 1;
    int  phase = 0;
    int  rises = 0;
    logic irq_prev = 1'b0;
    bit  finished = 1'b0;

    uart_rx_dbuf dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .fmt(fmt),
        .wake_en(wake_en), .irq_edge(irq_edge), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_flag(rx_flag), .overrun(overrun), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        tick16 = (phase == 0);
        phase  = (phase + 1) % tick_div;
        if (irq && !irq_prev) rises++;
        irq_prev = irq;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(logic [8:0] bits, int nb);
        int per;
        per = 16 * tick_div;
        @(negedge clk) rxd = 1'b0;
        repeat (per) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = bits[i];
            repeat (per) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (per + 8) @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    function automatic string vtag(int i);
        case (i)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R9";
            4, 5, 6: return "R7";
            7, 9: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic int nbits_of(logic [1:0] f);
        return (f == 2'd0) ? 7 : (f == 2'd1) ? 8 : 9;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 data", 32'(rx_data), 0);
        check("R1 flag", 32'(rx_flag), 0);
        check("R1 ovr", 32'(overrun), 0);
        check("R1 irq", 32'(irq), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            fmt = VECS[v].fmt;
            wake_en = VECS[v].wake;
            irq_edge = VECS[v].edg;
            if (VECS[v].rd) pulse_rd();
            repeat (3) @(negedge clk);
            rises = 0;
            send(VECS[v].bits, nbits_of(VECS[v].fmt));
            check({vtag(v), " data"}, 32'(rx_data), 32'(VECS[v].d));
            check({vtag(v), " flag"}, 32'(rx_flag), 32'(VECS[v].b9));
            check({vtag(v), " ovr"}, 32'(overrun), 32'(VECS[v].ovr));
            check({vtag(v), " R8 irq level"}, 32'(irq), 32'(VECS[v].irqv));
            check({vtag(v), " R9 irq events"}, 32'(rises), 32'(VECS[v].rise));
        end

        // R6: read strobe lands in the same cycle as the transfer
        fmt = 2'd1; wake_en = 1'b0; irq_edge = 1'b0;
        repeat (3) @(negedge clk);
        fork
            send(9'h077, 8);
            begin
                repeat (137) @(negedge clk);
                rd_strobe = 1'b1;
                @(negedge clk) rd_strobe = 1'b0;
            end
        join
        check("R6 collision data", 32'(rx_data), 32'h77);
        check("R6 collision ovr", 32'(overrun), 0);
        check("R6 collision irq", 32'(irq), 1);

        // R10: short low glitch is not a start bit
        pulse_rd();
        repeat (3) @(negedge clk);
        rises = 0;
        rxd = 1'b0;
        repeat (5) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        check("R10 glitch data", 32'(rx_data), 32'h77);
        check("R10 glitch irq", 32'(rises), 0);

        // R11: sampling ticks every second cycle
        tick_div = 2;
        repeat (4) @(negedge clk);
        rises = 0;
        send(9'h096, 8);
        check("R11 slow tick data", 32'(rx_data), 32'h96);
        check("R11 slow tick irq", 32'(irq), 1);
        tick_div = 1;

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 rerst data", 32'(rx_data), 0);
        check("R1 rerst irq", 32'(irq), 0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule